// File: doc/BRIEF.md
# Serial Card Host Interface

This block is the host-side front end of a plug-in serial card built around a 16550-style UART. The host makes byte accesses, and the block decodes only odd byte offsets, so each register sits two bytes above the one before it. The low window holds four card-level registers. Offset 0x01 reads back the card identity and the position of a remote/local switch, and a write there resets the card. Offset 0x03 controls the interrupt. Offsets 0x05 and 0x07 are general configuration bytes.

A second window, from 0x11 to 0x1D, passes each access through to the UART register file. The seven UART registers appear in order as data, interrupt enable, interrupt identify/FIFO control, line control, modem control, line status and modem status, and the block hands the UART a 3-bit register index.

The block gates the UART interrupt line with a card-level enable. It also reports an interrupt priority level, computed from a two-bit strap plus three. Any address the block does not decode reads as 0xFF and ignores writes.

Top module: `serial_card_front`

## Requirements
- R1: A read of offset 0x01 returns 0x02 when parameter ALT_ID is 0, or 0x42 when ALT_ID is 1, with bit 7 replaced by the level of `remote_sw`.
- R2: A write of any value to offset 0x01 raises `uart_reset` for exactly 4 clock cycles, starting with the cycle after the write. Those cycles clear the interrupt enable and both configuration bytes to 0.
- R3: While `uart_reset` is high, accesses to the UART window produce no `uart_wr` or `uart_rd` strobe, and reads of that window return 0xFF.
- R4: A read of offset 0x03 returns the interrupt enable in bit 7, the live `uart_irq` level in bit 6, `ipl_strap` in bits 5:4 and zeros in bits 3:0. A write there sets the enable from bit 7 and ignores bits 6:0.
- R5: `card_irq` is high exactly when the interrupt enable is 1 and `uart_irq` is high.
- R6: `irq_level` equals `ipl_strap` + 3, which gives a value from 3 to 6.
- R7: An access at offset 0x11 + 2*k (k = 0..6) drives `uart_addr` = k. A write raises `uart_wr` with `uart_wdata` = the bus data for that cycle. A read raises `uart_rd` and returns `uart_rdata` on `bus_rdata`.
- R8: Offsets 0x05 and 0x07 are independent 8-bit read/write configuration bytes.
- R9: A read of an undecoded offset (any even offset, 0x09 to 0x0F, 0x1F, or 0x20 and above) returns 0xFF. A write there changes no register and produces no UART strobe.
- R10: While `rst_n` is low, `uart_reset` is high. After reset, the enable and both configuration bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Host byte offset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| remote_sw | input | 1 | Remote/local switch level |
| ipl_strap | input | 2 | Static priority strap |
| uart_irq | input | 1 | UART interrupt request |
| card_irq | output | 1 | Gated card interrupt |
| irq_level | output | 3 | Interrupt priority level |
| uart_reset | output | 1 | Reset to the UART, active high |
| uart_addr | output | 3 | UART register index |
| uart_wr | output | 1 | UART write strobe |
| uart_rd | output | 1 | UART read strobe |
| uart_wdata | output | 8 | UART write data |
| uart_rdata | input | 8 | UART read data |

## Verification
On every cycle, the assertions check four properties: the gated interrupt never rises without the UART request, no UART strobe appears while the reset is active or for an undecoded offset, the priority level stays between 3 and 6, and every reset pulse lasts exactly four cycles and follows a write to the identity offset. The directed scenarios cover the rest. These include the identity values for both variants and both switch positions, the register index sent for each window offset, the read-only bits of the interrupt control register, the clearing of registers by a soft reset, and the proof that writes to undecoded or blocked addresses leave the UART stub and the card registers unchanged.

// File: rtl/serial_card_front.sv
module serial_card_front #(
  parameter int ADDR_W  = 8,
  parameter bit ALT_ID  = 1'b0,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              remote_sw,
  input  logic [1:0]        ipl_strap,
  input  logic              uart_irq,
  output logic              card_irq,
  output logic [2:0]        irq_level,
  output logic              uart_reset,
  output logic [2:0]        uart_addr,
  output logic              uart_wr,
  output logic              uart_rd,
  output logic [7:0]        uart_wdata,
  input  logic [7:0]        uart_rdata
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [7:0] ID_VAL = ALT_ID ? 8'h42 : 8'h02;

  logic [CW-1:0] rst_cnt;
  logic          soft_rst;
  logic          ie_q;
  logic [7:0]    cfg_a, cfg_b;
  logic          in_range, card_hit, chip_hit;

  assign in_range = (bus_addr[ADDR_W-1:5] == '0) && bus_addr[0];
  assign card_hit = in_range && (bus_addr[4:3] == 2'b00);
  assign chip_hit = in_range && bus_addr[4] && (bus_addr[3:1] != 3'b111);
  assign soft_rst = (rst_cnt != '0);
  assign uart_reset = soft_rst || !rst_n;

  assign uart_addr  = bus_addr[3:1];
  assign uart_wdata = bus_wdata;
  assign uart_wr    = bus_wr && chip_hit && !uart_reset;
  assign uart_rd    = bus_rd && chip_hit && !uart_reset;

  assign card_irq  = ie_q && uart_irq;
  assign irq_level = {1'b0, ipl_strap} + 3'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt <= '0;
    end else if (bus_wr && card_hit && bus_addr[2:1] == 2'd0) begin
      rst_cnt <= CW'(RST_CYC);
    end else if (soft_rst) begin
      rst_cnt <= rst_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      cfg_a <= '0;
      cfg_b <= '0;
    end else if (soft_rst) begin
      ie_q  <= 1'b0;
      cfg_a <= '0;
      cfg_b <= '0;
    end else if (bus_wr && card_hit) begin
      case (bus_addr[2:1])
        2'd1:    ie_q  <= bus_wdata[7];
        2'd2:    cfg_a <= bus_wdata;
        2'd3:    cfg_b <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = 8'hFF;
    if (card_hit) begin
      case (bus_addr[2:1])
        2'd0:    bus_rdata = {remote_sw, ID_VAL[6:0]};
        2'd1:    bus_rdata = {ie_q, uart_irq, ipl_strap, 4'b0000};
        2'd2:    bus_rdata = cfg_a;
        default: bus_rdata = cfg_b;
      endcase
    end else if (chip_hit && !uart_reset) begin
      bus_rdata = uart_rdata;
    end
  end

  logic [CW:0] pulse_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pulse_len <= '0;
    else if (!uart_reset)   pulse_len <= '0;
    else                    pulse_len <= pulse_len + 1'b1;
  end

  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    card_irq |-> uart_irq);
  assert_no_strobe_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uart_reset |-> !(uart_wr || uart_rd));
  assert_level_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level >= 3'd3 && irq_level <= 3'd6);
  assert_undecoded_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_wr || uart_rd) |-> (bus_addr[0] && bus_addr[ADDR_W-1:4] == 1));
  assert_reset_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1)) |=> uart_reset);
  assert_reset_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_reset && $past(uart_reset) && !$past(bus_wr && bus_addr == ADDR_W'(1)))
      |-> pulse_len <= (CW+1)'(RST_CYC));
  assert_reset_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_len == (CW+1)'(RST_CYC) && !$past(bus_wr && bus_addr == ADDR_W'(1)))
      |-> !uart_reset);
endmodule

// File: tb/tb_serial_card_front.sv
module tb_serial_card_front;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, alt_rdata;
  logic       remote_sw = 0;
  logic [1:0] ipl_strap = 2'd0;
  logic       uart_irq = 0;
  logic       card_irq;
  logic [2:0] irq_level;
  logic       uart_reset;
  logic [2:0] uart_addr;
  logic       uart_wr, uart_rd;
  logic [7:0] uart_wdata, uart_rdata;
  logic       a_irq, a_rst, a_wr, a_rd;
  logic [2:0] a_lvl, a_addr;
  logic [7:0] a_wd;
  logic [7:0] stub [8];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  serial_card_front dut (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .remote_sw, .ipl_strap, .uart_irq, .card_irq, .irq_level, .uart_reset,
    .uart_addr, .uart_wr, .uart_rd, .uart_wdata, .uart_rdata);

  serial_card_front #(.ALT_ID(1'b1)) dut_alt (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata(alt_rdata),
    .remote_sw, .ipl_strap, .uart_irq, .card_irq(a_irq), .irq_level(a_lvl),
    .uart_reset(a_rst), .uart_addr(a_addr), .uart_wr(a_wr), .uart_rd(a_rd),
    .uart_wdata(a_wd), .uart_rdata(uart_rdata));

  assign uart_rdata = stub[uart_addr];
  always_ff @(posedge clk) if (uart_wr) stub[uart_addr] <= uart_wdata;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    chk("R10 uart_reset during rst_n", {7'b0, uart_reset}, 8'h01);
    @(negedge clk); rst_n = 1;
    rd(8'h03, d); chk("R10 enable after reset", d & 8'h80, 8'h00);
    rd(8'h05, d); chk("R10 cfg_a after reset", d, 8'h00);
    rd(8'h07, d); chk("R10 cfg_b after reset", d, 8'h00);
    chk("R10 uart_reset released", {7'b0, uart_reset}, 8'h00);
  endtask

  task automatic t_id();
    logic [7:0] d;
    remote_sw = 0;
    @(negedge clk); bus_addr = 8'h01; #1;
    chk("R1 base id", bus_rdata, 8'h02);
    chk("R1 alt id", alt_rdata, 8'h42);
    remote_sw = 1; #1;
    chk("R1 base id remote", bus_rdata, 8'h82);
    chk("R1 alt id remote", alt_rdata, 8'hC2);
    remote_sw = 0;
    rd(8'h01, d); chk("R1 id read", d, 8'h02);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    for (int s = 0; s < 4; s++) begin
      ipl_strap = 2'(s); #1;
      chk("R6 level", {5'b0, irq_level}, 8'(s + 3));
    end
    ipl_strap = 2'd2;
    wr(8'h03, 8'h7F);
    uart_irq = 1; #1;
    chk("R5 irq gated off", {7'b0, card_irq}, 8'h00);
    rd(8'h03, d); chk("R4 ctrl ro bits", d, 8'h60);
    wr(8'h03, 8'h80);
    rd(8'h03, d); chk("R4 ctrl enabled", d, 8'hE0);
    chk("R5 irq on", {7'b0, card_irq}, 8'h01);
    uart_irq = 0; #1;
    chk("R5 irq follows uart", {7'b0, card_irq}, 8'h00);
    rd(8'h03, d); chk("R4 raw req low", d, 8'hA0);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    wr(8'h05, 8'hA5); wr(8'h07, 8'h3C);
    rd(8'h05, d); chk("R8 cfg_a", d, 8'hA5);
    rd(8'h07, d); chk("R8 cfg_b", d, 8'h3C);
  endtask

  task automatic t_chip();
    logic [7:0] d;
    for (int k = 0; k < 7; k++) wr(8'(8'h11 + 2 * k), 8'(8'h50 + k));
    for (int k = 0; k < 7; k++) chk("R7 stub index", stub[k], 8'(8'h50 + k));
    for (int k = 0; k < 7; k++) begin
      rd(8'(8'h11 + 2 * k), d); chk("R7 window read", d, 8'(8'h50 + k));
    end
    @(negedge clk); bus_addr = 8'h17; bus_rd = 1; #1;
    chk("R7 rd strobe", {uart_rd, uart_addr, 4'b0}, 8'hB0);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic t_undecoded();
    logic [7:0] d;
    logic [7:0] addrs [6] = '{8'h02, 8'h09, 8'h10, 8'h1F, 8'h21, 8'h45};
    stub[7] = 8'h11;
    foreach (addrs[i]) begin
      @(negedge clk); bus_addr = addrs[i]; bus_wdata = 8'h00; bus_wr = 1; #1;
      chk("R9 no strobe", {6'b0, uart_wr, uart_reset}, 8'h00);
      @(negedge clk); bus_wr = 0;
      rd(addrs[i], d); chk("R9 reads FF", d, 8'hFF);
    end
    rd(8'h05, d); chk("R9 cfg_a kept", d, 8'hA5);
    rd(8'h07, d); chk("R9 cfg_b kept", d, 8'h3C);
    rd(8'h03, d); chk("R9 enable kept", d & 8'h80, 8'h80);
    chk("R9 stub kept", stub[7], 8'h11);
    for (int k = 0; k < 7; k++) chk("R9 stub window kept", stub[k], 8'(8'h50 + k));
  endtask

  task automatic t_soft_reset();
    int hi = 0;
    @(negedge clk); bus_addr = 8'h01; bus_wdata = 8'h5A; bus_wr = 1;
    #1 chk("R2 not yet in reset", {7'b0, uart_reset}, 8'h00);
    @(negedge clk); bus_wr = 0;
    for (int c = 0; c < 6; c++) begin
      if (uart_reset) hi++;
      if (c == 1) begin
        bus_addr = 8'h13; bus_wdata = 8'hEE; bus_wr = 1; #1;
        chk("R3 no wr strobe", {7'b0, uart_wr}, 8'h00);
        bus_wr = 0; bus_rd = 1; #1;
        chk("R3 read FF", bus_rdata, 8'hFF);
        chk("R3 no rd strobe", {7'b0, uart_rd}, 8'h00);
        bus_rd = 0;
      end
      @(negedge clk);
    end
    chk("R2 pulse length", 8'(hi), 8'd4);
    chk("R3 stub untouched", stub[1], 8'h51);
    begin
      logic [7:0] d;
      rd(8'h03, d); chk("R2 enable cleared", d & 8'h80, 8'h00);
      rd(8'h05, d); chk("R2 cfg_a cleared", d, 8'h00);
      rd(8'h07, d); chk("R2 cfg_b cleared", d, 8'h00);
    end
  endtask

  initial begin
    fork
      begin
        for (int k = 0; k < 8; k++) stub[k] = '0;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_id();
        t_irq();
        t_cfg();
        t_chip();
        t_undecoded();
        t_soft_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule